// File: doc/BRIEF.md
# System Control and Reset Register Block

This block is a small memory-mapped register file that sits on a single-cycle word bus. It holds three registers. The first is an identification word whose version, platform and boot-source fields are fixed at build time; its middle byte can be written by software only while the boot ROM is still enabled. The second is a soft-reset control register. The third is a register of peripheral reset levels.

Writing a 1 to bit 0 of the soft-reset register when that bit was 0 does three things. It disables the boot ROM at once, which also locks the identification byte. It starts a delay counter. When the counter expires, the block raises the CPU reset output for a fixed number of cycles. The peripheral reset register drives one output line per bit, and each line follows the stored bit level. Software resets a peripheral by setting its bit and later clearing it.

Reads return data combinationally from the current address. A write takes effect on the clock edge on which `wr_en` is high. The register offsets are 0x00 for the identification word, 0x04 for soft reset and 0x08 for the peripheral resets. Any other offset is unmapped.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, offset 0x00 reads 0x00041040, offsets 0x04 and 0x08 read 0, `boot_rom_en` is 1, `cpu_rst` is 0 and `periph_rst` is all zero.
- R2: While `boot_rom_en` is 1, a write to offset 0x00 replaces ID bits 15:8 with the written bits. ID bits 31:16 and 7:0 keep their values whatever is written.
- R3: Once `boot_rom_en` is 0, writes to offset 0x00 leave the whole ID word unchanged.
- R4: A write of 1 to bit 0 at offset 0x04, while that bit reads 0 and no soft reset is in progress, is counted as write edge E. `cpu_rst` is then 1 exactly in the cycles following edges E+16 through E+19, which is 4 cycles, and 0 otherwise.
- R5: Writing 1 to bit 0 at offset 0x04 while that bit already reads 1 does not produce a `cpu_rst` pulse.
- R6: A write that starts a soft reset clears `boot_rom_en` from the following cycle. It stays 0 until the block is reset.
- R7: A write of 0 followed by a write of 1 to offset 0x04 during the delay or pulse changes neither the pulse timing nor the number of pulses.
- R8: Writing offset 0x08 sets `periph_rst[i]` to written bit i for i in 0..21. The level then holds until the next write to that offset.
- R9: Bits 31:22 of offset 0x08 always read 0, and writes to those bits have no effect on any output.
- R10: Bit 0 of offset 0x04 reads back the last value written to it. Its other bits read 0.
- R11: Reads of unmapped offsets return 0, and writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| cpu_rst | output | 1 | Delayed CPU reset pulse |
| boot_rom_en | output | 1 | High until the first soft reset |
| periph_rst | output | 22 | Peripheral reset levels |

## Verification
A delay counter that restarts, or an edge detector that keeps the wrong prior bit value, shows up directly at `cpu_rst`. The pulse appears early, late, twice, or not at all, so each run must be sampled cycle by cycle over the full 20-cycle window after the triggering write. A lock flag held in the wrong state shows at the first ID write after a soft reset, as a changed middle byte on the read that follows. A dropped or leaked bit in the peripheral register appears on the same cycle as the write, both at `periph_rst` and on readback. The bench therefore sweeps all 256 byte values, walks every reset line and times every pulse against edge counts.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    typedef logic [31:0] word_t;

    typedef enum logic [1:0] {
        SEL_ID     = 2'd0,
        SEL_SOFT   = 2'd1,
        SEL_PERIPH = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        SR_IDLE  = 2'd0,
        SR_WAIT  = 2'd1,
        SR_PULSE = 2'd2
    } sr_state_e;

    typedef struct packed {
        logic     wr;
        reg_sel_e sel;
        word_t    data;
    } bus_req_t;

    localparam int OFS_ID     = 'h00;
    localparam int OFS_SOFT   = 'h04;
    localparam int OFS_PERIPH = 'h08;

    function automatic word_t field_mask(input int lsb, input int width);
        word_t m;
        m = '0;
        for (int i = 0; i < 32; i++) begin
            if (i >= lsb && i < lsb + width) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic word_t merge_field(input word_t base, input word_t fld, input word_t mask);
        return (base & ~mask) | (fld & mask);
    endfunction

endpackage

// File: rtl/sysctl_id_reg.sv
module sysctl_id_reg
    import sysctl_pkg::*;
#(
    parameter logic [31:0] ID_RESET  = 32'h00041040,
    parameter int          FIELD_LSB = 8,
    parameter int          FIELD_W   = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_stb,
    input  word_t wr_data,
    input  logic  unlocked,
    output word_t id_word
);
    localparam word_t MASK = field_mask(FIELD_LSB, FIELD_W);

    logic [FIELD_W-1:0] field_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            field_q <= ID_RESET[FIELD_LSB +: FIELD_W];
        end else if (wr_stb && unlocked) begin
            field_q <= wr_data[FIELD_LSB +: FIELD_W];
        end
    end

    always_comb begin
        id_word = ID_RESET;
        id_word[FIELD_LSB +: FIELD_W] = field_q;
    end

    // Field is frozen once the boot ROM is off
    assert_id_lock_R3: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> $stable(field_q));

    // Bits outside the field never differ from the build-time value
    assert_id_fixed_R2: assert property (@(posedge clk) disable iff (rst)
        (id_word & ~MASK) == (ID_RESET & ~MASK));

endmodule

// File: rtl/sysctl_soft_reset.sv
module sysctl_soft_reset
    import sysctl_pkg::*;
#(
    parameter int DELAY_CYC = 16,
    parameter int PULSE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_stb,
    input  logic wr_bit,
    output logic bit_q,
    output logic cpu_rst,
    output logic boot_en
);
    localparam int MAXC  = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(DELAY_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);

    sr_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic             trig;

    assign trig    = wr_stb && wr_bit && !bit_q && (state == SR_IDLE);
    assign cpu_rst = (state == SR_PULSE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SR_IDLE;
            cnt     <= '0;
            bit_q   <= 1'b0;
            boot_en <= 1'b1;
        end else begin
            if (wr_stb) bit_q <= wr_bit;
            unique case (state)
                SR_IDLE: begin
                    if (trig) begin
                        state   <= SR_WAIT;
                        cnt     <= '0;
                        boot_en <= 1'b0;
                    end
                end
                SR_WAIT: begin
                    if (cnt == WAIT_LAST) begin
                        state <= SR_PULSE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SR_PULSE: begin
                    if (cnt == PULSE_LAST) begin
                        state <= SR_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= SR_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Pulse length measured independently of the state counter
    logic [CNT_W:0] run_len;
    always_ff @(posedge clk) begin
        if (rst)          run_len <= '0;
        else if (cpu_rst) run_len <= run_len + 1'b1;
        else              run_len <= '0;
    end

    assert_pulse_len_R4: assert property (@(posedge clk) disable iff (rst)
        run_len <= (CNT_W+1)'(PULSE_CYC));

    assert_no_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (state == SR_WAIT && cnt != WAIT_LAST) |=> (state == SR_WAIT && cnt == $past(cnt) + 1'b1));

    assert_boot_off_R6: assert property (@(posedge clk) disable iff (rst)
        cpu_rst |-> !boot_en);

    assert_boot_stays_off_R6: assert property (@(posedge clk) disable iff (rst)
        !boot_en |=> !boot_en);

endmodule

// File: rtl/sysctl_periph_reset.sv
module sysctl_periph_reset
    import sysctl_pkg::*;
#(
    parameter int LINES = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_stb,
    input  word_t            wr_data,
    output logic [LINES-1:0] lines,
    output word_t            rd_word
);
    logic [LINES-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst)         lvl_q <= '0;
        else if (wr_stb) lvl_q <= wr_data[LINES-1:0];
    end

    assign lines = lvl_q;

    generate
        if (LINES < 32) begin : g_pad
            assign rd_word = {{(32-LINES){1'b0}}, lvl_q};
        end else begin : g_full
            assign rd_word = lvl_q[31:0];
        end
    endgenerate

    assert_periph_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(lines));

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          PERIPH_N  = 22,
    parameter logic [31:0] ID_RESET  = 32'h00041040,
    parameter int          FIELD_LSB = 8,
    parameter int          FIELD_W   = 8,
    parameter int          DELAY_CYC = 16,
    parameter int          PULSE_CYC = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    output logic                cpu_rst,
    output logic                boot_rom_en,
    output logic [PERIPH_N-1:0] periph_rst
);
    bus_req_t req;
    word_t    id_word, periph_word;
    logic     soft_bit;

    always_comb begin
        req.wr   = wr_en;
        req.data = wdata;
        if (addr == ADDR_W'(OFS_ID))          req.sel = SEL_ID;
        else if (addr == ADDR_W'(OFS_SOFT))   req.sel = SEL_SOFT;
        else if (addr == ADDR_W'(OFS_PERIPH)) req.sel = SEL_PERIPH;
        else                                  req.sel = SEL_NONE;
    end

    sysctl_id_reg #(
        .ID_RESET (ID_RESET),
        .FIELD_LSB(FIELD_LSB),
        .FIELD_W  (FIELD_W)
    ) u_id (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (req.wr && req.sel == SEL_ID),
        .wr_data (req.data),
        .unlocked(boot_rom_en),
        .id_word (id_word)
    );

    sysctl_soft_reset #(
        .DELAY_CYC(DELAY_CYC),
        .PULSE_CYC(PULSE_CYC)
    ) u_soft (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (req.wr && req.sel == SEL_SOFT),
        .wr_bit (req.data[0]),
        .bit_q  (soft_bit),
        .cpu_rst(cpu_rst),
        .boot_en(boot_rom_en)
    );

    sysctl_periph_reset #(
        .LINES(PERIPH_N)
    ) u_periph (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (req.wr && req.sel == SEL_PERIPH),
        .wr_data(req.data),
        .lines  (periph_rst),
        .rd_word(periph_word)
    );

    always_comb begin
        unique case (req.sel)
            SEL_ID:     rdata = id_word;
            SEL_SOFT:   rdata = {31'b0, soft_bit};
            SEL_PERIPH: rdata = periph_word;
            default:    rdata = '0;
        endcase
    end

    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (req.sel == SEL_NONE) |-> (rdata == '0));

endmodule

// File: tb/sysctl_regs_bench.sv
`timescale 1ns/1ps
module sysctl_regs_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        cpu_rst, boot_rom_en;
    logic [21:0] periph_rst;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [31:0] ID_INIT = 32'h00041040;

    always #2.5 clk = ~clk;

    sysctl_regs u_sysctl_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cpu_rst(cpu_rst), .boot_rom_en(boot_rom_en),
        .periph_rst(periph_rst)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // Called right after the triggering write returns (k = 0)
    task automatic expect_pulse(input string req, input int first);
        for (int k = 0; k < 28; k++) begin
            chk(req, {31'b0, cpu_rst}, {31'b0, (k >= first && k < first + 4)});
            @(negedge clk);
        end
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        do_reset();

        // R1: reset state
        do_read(8'h00, r); chk("R1 id", r, ID_INIT);
        do_read(8'h04, r); chk("R1 soft", r, 0);
        do_read(8'h08, r); chk("R1 periph", r, 0);
        chk("R1 boot_en", {31'b0, boot_rom_en}, 1);
        chk("R1 cpu_rst", {31'b0, cpu_rst}, 0);
        chk("R1 lines", {10'b0, periph_rst}, 0);

        // R2: sweep every middle-byte value, other bits written inverted
        for (int v = 0; v < 256; v++) begin
            do_write(8'h00, (~ID_INIT & 32'hFFFF00FF) | (32'(v) << 8));
            do_read(8'h00, r);
            chk("R2 id field", r, (ID_INIT & 32'hFFFF00FF) | (32'(v) << 8));
        end

        // R8 / R9: walk each line, upper bits set alongside
        for (int i = 0; i < 22; i++) begin
            do_write(8'h08, 32'hFFC00000 | (32'd1 << i));
            chk("R8 line", {10'b0, periph_rst}, 32'd1 << i);
            repeat (2) @(negedge clk);
            chk("R8 hold", {10'b0, periph_rst}, 32'd1 << i);
            do_read(8'h08, r); chk("R9 readback", r, 32'd1 << i);
        end
        do_write(8'h08, 32'hFFFFFFFF);
        do_read(8'h08, r); chk("R9 all ones", r, 32'h003FFFFF);
        do_write(8'h08, 32'hFFC00000);
        do_read(8'h08, r); chk("R9 upper only", r, 0);
        chk("R9 lines", {10'b0, periph_rst}, 0);

        // R11: unmapped offsets
        do_write(8'h08, 32'h00155555);
        for (int a = 12; a < 256; a += 4) begin
            do_write(8'(a), 32'hFFFFFFFF);
            do_read(8'(a), r); chk("R11 read zero", r, 0);
        end
        chk("R11 lines", {10'b0, periph_rst}, 32'h00155555);
        chk("R11 cpu_rst", {31'b0, cpu_rst}, 0);
        chk("R11 boot_en", {31'b0, boot_rom_en}, 1);
        do_read(8'h04, r); chk("R11 soft", r, 0);

        // R4 / R6 / R7: trigger, then 0 and 1 written during the delay
        do_reset();
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h04; wdata = 32'hFFFFFFFF;
        for (int k = 0; k < 28; k++) begin
            @(negedge clk);
            wr_en = 1'b0;
            chk("R4/R7 pulse", {31'b0, cpu_rst}, {31'b0, (k >= 16 && k < 20)});
            chk("R6 boot_en", {31'b0, boot_rom_en}, 0);
            if (k == 4)  begin wr_en = 1'b1; addr = 8'h04; wdata = 32'h0; end
            if (k == 7)  begin wr_en = 1'b1; addr = 8'h04; wdata = 32'h1; end
            if (k == 17) begin wr_en = 1'b1; addr = 8'h04; wdata = 32'h0; end
            if (k == 18) begin wr_en = 1'b1; addr = 8'h04; wdata = 32'h1; end
        end
        do_read(8'h04, r); chk("R10 soft readback", r, 1);

        // R3: ID locked after soft reset
        do_write(8'h00, 32'h0000AB00);
        do_read(8'h00, r); chk("R3 id locked", r, ID_INIT);

        // R5: 1 over 1 gives no pulse
        do_write(8'h04, 32'h1);
        expect_pulse("R5 no pulse", 100);

        // R4: clean 0 then 1 after idle starts a fresh pulse
        do_write(8'h04, 32'h0);
        do_read(8'h04, r); chk("R10 soft zero", r, 0);
        do_write(8'h04, 32'h1);
        expect_pulse("R4 second pulse", 16);
        chk("R6 boot_en held", {31'b0, boot_rom_en}, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule